// File: doc/BRIEF.md
# Memory Access Ordering Token Network

This block sequences a fixed set of memory operations (loads, stores and forwarders) with single-bit token places. A memory-order activate token enters at the root nodes, and each operation waits for two things before it fires: its memory-order token and an activate token on one of its control edges. A load or store then raises a request on the memory port it is bound to and holds it until the port acknowledges. The acknowledge cycle produces a completion token, and that token travels over memory-order edges to the node's successors. A forwarder stands in for a branch that has no access. It makes no request and relays the token on the cycle after both of its tokens are present.

Memory-order edges carry only activate tokens. A node with several memory predecessors joins them in one of two ways. An AND join waits until every predecessor has completed. An OR join fires on any completion. Each node has two control edges, A and B, and each edge has a qualifier. The qualifier decides whether that edge admits activate tokens, cancel tokens, both, or neither. This lets an inner-loop exit enable a store while the outer-loop condition kills the same store.

Stores hold a cancel token in a place of their own. When a cancel is consumed, the store signals a backward cancel toward its address and write-data producers. Loads ignore control-edge cancels. They can only be cancelled through their result edge. Arbitration, caches and address generation belong to the surrounding system.

Each node runs a three-state machine:
- `ND_IDLE`: the node collects tokens.
- `ND_ISSUE`: the node's port request is raised.
- `ND_DRAIN`: a load cancelled after issue waits here for its acknowledge and then discards the result.

The transitions are:
- IDLE→ISSUE when both tokens are present.
- IDLE→IDLE when a kill clears the tokens, or when a forwarder relays its token.
- ISSUE→IDLE on acknowledge.
- ISSUE→DRAIN on a load result cancel.
- DRAIN→IDLE on acknowledge.

Top module: `mo_order_net`

## Requirements
- R1: After reset, `port_req`, `port_write`, `node_done` and `data_cancel` are all zero.
- R2: A load or store raises its port request two cycles after the later of its two tokens arrives: the memory-order token and an admitted control activate token. Either token alone, in any order, never causes a request. Stores are therefore never speculative.
- R3: A request stays high until the cycle in which its port acknowledges. The node's `node_done` bit pulses in that same acknowledge cycle, and the request drops on the next cycle.
- R4: A node whose bit in `JOIN_ALL` is set receives its memory-order token only once every predecessor in its `PRED_MASK` row has completed. The completions may arrive in different cycles or in the same cycle.
- R5: A node with an OR join receives its memory-order token from the first completion of any one of its predecessors.
- R6: A forwarder (kind code 2) pulses `node_done` one cycle after both of its tokens are present. It never requests a port and never accepts a cancel token.
- R7: Qualifier bit 0 lets an edge pass activate tokens, and bit 1 lets it pass cancel tokens. A token the qualifier blocks is dropped. In the default configuration, node 1 has edge A set to activate-only (01) and edge B set to cancel-only (10).
- R8: A cancel admitted to a store (kind code 1) is held in the store's kill place. While the store is idle, the cancel takes priority over issuing. It produces a one-cycle `data_cancel` pulse one cycle after it arrives, clears the store's tokens, and leads to no request.
- R9: A load (kind code 0) never admits a control-edge cancel. A `res_cancel` pulse while the load is idle clears the tokens it has collected.
- R10: A `res_cancel` pulse while a load is requesting keeps the request held until acknowledge. That acknowledge yields no completion token.
- R11: Memory-order edges carry no cancel. A cancelled node emits no completion token, and its successors wait for other predecessors.
- R12: Node n requests port `NODE_PORT[4n+3:4n]`. `port_write` is high together with the request exactly when the requesting node is a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_start | input | 1 | Memory-order activate token for root nodes |
| ctl_a_act | input | NUM_NODES | Activate token on control edge A, per node |
| ctl_a_can | input | NUM_NODES | Cancel token on control edge A, per node |
| ctl_b_act | input | NUM_NODES | Activate token on control edge B, per node |
| ctl_b_can | input | NUM_NODES | Cancel token on control edge B, per node |
| res_cancel | input | NUM_NODES | Cancel arriving on a load's result edge |
| port_ack | input | NUM_PORTS | Per-port acknowledge |
| port_req | output | NUM_PORTS | Per-port request |
| port_write | output | NUM_PORTS | The request on this port is a store |
| node_done | output | NUM_NODES | Completion token pulse, per node |
| data_cancel | output | NUM_NODES | Backward cancel from a store to its address and data inputs |

## Verification
Token inputs are captured on the edge after they are driven. A request therefore appears at the second sampling point after the later token, and the bench checks "not yet" at the first point and "now" at the second. Completion and the OR-join pulse are combinational on the acknowledge cycle. A store's backward cancel appears one cycle after its cancel token. The bench drives on the falling edge and samples 2 ns later for direct checks and 3 ns later for the completion monitor. The monitor pops an ordered queue of expected completing nodes, so a missing, extra or reordered completion is reported.

// File: rtl/mo_pkg.sv
package mo_pkg;

    // Node kinds; the codes are also the parameter encoding
    typedef enum logic [1:0] {
        MO_LOAD  = 2'd0,
        MO_STORE = 2'd1,
        MO_FWD   = 2'd2
    } mo_kind_e;

    // Per-node sequencing states
    typedef enum logic [1:0] {
        ND_IDLE  = 2'd0,
        ND_ISSUE = 2'd1,
        ND_DRAIN = 2'd2
    } mo_state_e;

    // Width of each node's port-number field in NODE_PORT
    localparam int PORT_FW = 4;

    // Qualifier bit positions
    localparam int Q_ACT = 0;
    localparam int Q_CAN = 1;

endpackage

// File: rtl/mo_ctl_filter.sv
module mo_ctl_filter
    import mo_pkg::*;
#(
    parameter mo_kind_e   KIND = MO_LOAD,
    parameter logic [1:0] QA   = 2'b11,
    parameter logic [1:0] QB   = 2'b00
) (
    input  logic act_a,
    input  logic can_a,
    input  logic act_b,
    input  logic can_b,
    output logic act_o,
    output logic can_o
);

    // Only stores own a place for a control-edge cancel
    localparam logic CAN_OK = (KIND == MO_STORE);

    logic act_pass_a, act_pass_b;
    logic can_pass_a, can_pass_b;

    always_comb begin
        act_pass_a = QA[Q_ACT] & act_a;
        act_pass_b = QB[Q_ACT] & act_b;
        can_pass_a = QA[Q_CAN] & can_a;
        can_pass_b = QB[Q_CAN] & can_b;
        act_o      = act_pass_a | act_pass_b;
        can_o      = CAN_OK & (can_pass_a | can_pass_b);
    end

endmodule

// File: rtl/mo_node.sv
module mo_node
    import mo_pkg::*;
#(
    parameter mo_kind_e KIND = MO_LOAD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ord_in,
    input  logic act_in,
    input  logic can_in,
    input  logic res_cancel,
    input  logic ack,
    output logic req,
    output logic is_write,
    output logic done,
    output logic bwd_cancel
);

    localparam logic IS_ST = (KIND == MO_STORE);
    localparam logic IS_LD = (KIND == MO_LOAD);
    localparam logic IS_FW = (KIND == MO_FWD);

    mo_state_e state_q, state_d;
    logic      ord_q, act_q, kill_q;
    logic      take, drop, drop_kill;

    // Next state and token consumption
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        drop      = 1'b0;
        drop_kill = 1'b0;
        unique case (state_q)
            ND_IDLE: begin
                if (IS_ST && kill_q) begin
                    drop      = 1'b1;
                    drop_kill = 1'b1;
                end else if (IS_LD && res_cancel) begin
                    drop = 1'b1;
                end else if (ord_q && act_q) begin
                    take = 1'b1;
                    if (!IS_FW) begin
                        state_d = ND_ISSUE;
                    end
                end
            end
            ND_ISSUE: begin
                if (ack) begin
                    state_d = ND_IDLE;
                end else if (IS_LD && res_cancel) begin
                    state_d = ND_DRAIN;
                end
            end
            ND_DRAIN: begin
                if (ack) begin
                    state_d = ND_IDLE;
                end
            end
            default: state_d = ND_IDLE;
        endcase
    end

    // State register and token places
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ND_IDLE;
            ord_q   <= 1'b0;
            act_q   <= 1'b0;
            kill_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ord_q   <= (ord_q && !take && !drop) || ord_in;
            act_q   <= (act_q && !take && !drop) || act_in;
            kill_q  <= (kill_q && !drop_kill) || can_in;
        end
    end

    // Outputs
    always_comb begin
        req        = 1'b0;
        is_write   = 1'b0;
        done       = 1'b0;
        bwd_cancel = 1'b0;
        unique case (state_q)
            ND_IDLE: begin
                done       = IS_FW && take;
                bwd_cancel = drop_kill;
            end
            ND_ISSUE: begin
                req      = 1'b1;
                is_write = IS_ST;
                done     = ack && !(IS_LD && res_cancel);
            end
            ND_DRAIN: begin
                req = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mo_order_net.sv
module mo_order_net
    import mo_pkg::*;
#(
    parameter int NUM_NODES = 5,
    parameter int NUM_PORTS = 2,
    parameter logic [2*NUM_NODES-1:0]         NODE_KIND = 10'b01_00_10_01_00,
    parameter logic [PORT_FW*NUM_NODES-1:0]   NODE_PORT = 20'h01010,
    parameter logic [NUM_NODES*NUM_NODES-1:0] PRED_MASK = 25'b01001_00110_00000_00000_00000,
    parameter logic [NUM_NODES-1:0]           JOIN_ALL  = 5'b10000,
    parameter logic [2*NUM_NODES-1:0]         QUAL_A    = 10'b11_11_11_01_11,
    parameter logic [2*NUM_NODES-1:0]         QUAL_B    = 10'b00_00_00_10_00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seq_start,
    input  logic [NUM_NODES-1:0] ctl_a_act,
    input  logic [NUM_NODES-1:0] ctl_a_can,
    input  logic [NUM_NODES-1:0] ctl_b_act,
    input  logic [NUM_NODES-1:0] ctl_b_can,
    input  logic [NUM_NODES-1:0] res_cancel,
    input  logic [NUM_PORTS-1:0] port_ack,
    output logic [NUM_PORTS-1:0] port_req,
    output logic [NUM_PORTS-1:0] port_write,
    output logic [NUM_NODES-1:0] node_done,
    output logic [NUM_NODES-1:0] data_cancel
);

    logic [NUM_NODES-1:0] ord_fire;
    logic [NUM_NODES-1:0] act_ok;
    logic [NUM_NODES-1:0] can_ok;
    logic [NUM_NODES-1:0] node_req;
    logic [NUM_NODES-1:0] node_wr;

    for (genvar i = 0; i < NUM_NODES; i++) begin : g_node
        localparam mo_kind_e       KIND_I = mo_kind_e'(NODE_KIND[2*i +: 2]);
        localparam int             PORT_I = int'(NODE_PORT[PORT_FW*i +: PORT_FW]);
        localparam logic [NUM_NODES-1:0] MASK_I = PRED_MASK[NUM_NODES*i +: NUM_NODES];

        // Memory-order join in front of the node
        if (MASK_I == '0) begin : g_root
            assign ord_fire[i] = seq_start;
        end else if (JOIN_ALL[i]) begin : g_and
            logic [NUM_NODES-1:0] seen_q;
            logic [NUM_NODES-1:0] hit;
            assign hit         = seen_q | (node_done & MASK_I);
            assign ord_fire[i] = (hit == MASK_I);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen_q <= '0;
                end else if (ord_fire[i]) begin
                    seen_q <= '0;
                end else begin
                    seen_q <= hit;
                end
            end
        end else begin : g_or
            assign ord_fire[i] = |(node_done & MASK_I);
        end

        mo_ctl_filter #(
            .KIND (KIND_I),
            .QA   (QUAL_A[2*i +: 2]),
            .QB   (QUAL_B[2*i +: 2])
        ) u_filt (
            .act_a (ctl_a_act[i]),
            .can_a (ctl_a_can[i]),
            .act_b (ctl_b_act[i]),
            .can_b (ctl_b_can[i]),
            .act_o (act_ok[i]),
            .can_o (can_ok[i])
        );

        mo_node #(
            .KIND (KIND_I)
        ) u_node (
            .clk        (clk),
            .rst_n      (rst_n),
            .ord_in     (ord_fire[i]),
            .act_in     (act_ok[i]),
            .can_in     (can_ok[i]),
            .res_cancel (res_cancel[i]),
            .ack        (port_ack[PORT_I]),
            .req        (node_req[i]),
            .is_write   (node_wr[i]),
            .done       (node_done[i]),
            .bwd_cancel (data_cancel[i])
        );
    end

    // Static binding of nodes onto ports
    always_comb begin
        port_req   = '0;
        port_write = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int n = 0; n < NUM_NODES; n++) begin
                if (int'(NODE_PORT[PORT_FW*n +: PORT_FW]) == p) begin
                    port_req[p]   = port_req[p] | node_req[n];
                    port_write[p] = port_write[p] | node_wr[n];
                end
            end
        end
    end

endmodule

// File: rtl/mo_order_net_chk.sv
module mo_order_net_chk
    import mo_pkg::*;
#(
    parameter int NUM_NODES = 5,
    parameter int NUM_PORTS = 2,
    parameter logic [2*NUM_NODES-1:0]       NODE_KIND = 10'b01_00_10_01_00,
    parameter logic [PORT_FW*NUM_NODES-1:0] NODE_PORT = 20'h01010
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] port_req,
    input logic [NUM_PORTS-1:0] port_ack,
    input logic [NUM_PORTS-1:0] port_write,
    input logic [NUM_NODES-1:0] node_done,
    input logic [NUM_NODES-1:0] data_cancel
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // R3: a request is held until acknowledged
        a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
            (port_req[p] && !port_ack[p]) |=> port_req[p]);

        // R12: the write flag does not change while a request waits
        a_r12_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (port_req[p] && !port_ack[p]) |=> $stable(port_write[p]));

        // R12: write flag only accompanies a request
        a_r12_write_with_req: assert property (@(posedge clk) disable iff (!rst_n)
            port_write[p] |-> port_req[p]);
    end

    for (genvar i = 0; i < NUM_NODES; i++) begin : g_nd
        localparam int PORT_I = int'(NODE_PORT[PORT_FW*i +: PORT_FW]);

        if (mo_kind_e'(NODE_KIND[2*i +: 2]) != MO_FWD) begin : g_acc
            // R3: an access completes only on its port's acknowledge
            a_r3_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
                node_done[i] |-> (port_req[PORT_I] && port_ack[PORT_I]));
        end

        // R8: a cancelled store never completes in the same cycle
        a_r8_cancel_not_done: assert property (@(posedge clk) disable iff (!rst_n)
            data_cancel[i] |-> !node_done[i]);
    end

endmodule

bind mo_order_net mo_order_net_chk #(
    .NUM_NODES (NUM_NODES),
    .NUM_PORTS (NUM_PORTS),
    .NODE_KIND (NODE_KIND),
    .NODE_PORT (NODE_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_req    (port_req),
    .port_ack    (port_ack),
    .port_write  (port_write),
    .node_done   (node_done),
    .data_cancel (data_cancel)
);

// File: tb/tb_mo_order_net.sv
module tb_mo_order_net;

    localparam int NN = 5;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_start = 1'b0;
    logic [NN-1:0] ctl_a_act = '0, ctl_a_can = '0, ctl_b_act = '0, ctl_b_can = '0;
    logic [NN-1:0] res_cancel = '0;
    logic [NP-1:0] port_ack = '0;
    logic [NP-1:0] port_req, port_write;
    logic [NN-1:0] node_done, data_cancel;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int done_cnt[NN];

    always #4 clk = ~clk;  // 125 MHz

    mo_order_net dut (
        .clk (clk), .rst_n (rst_n), .seq_start (seq_start),
        .ctl_a_act (ctl_a_act), .ctl_a_can (ctl_a_can),
        .ctl_b_act (ctl_b_act), .ctl_b_can (ctl_b_can),
        .res_cancel (res_cancel), .port_ack (port_ack),
        .port_req (port_req), .port_write (port_write),
        .node_done (node_done), .data_cancel (data_cancel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        chk("R3 every expected completion observed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; seq_start = 0; ctl_a_act = 0; ctl_a_can = 0;
        ctl_b_act = 0; ctl_b_can = 0; res_cancel = 0; port_ack = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < NN; n++) done_cnt[n] = 0;
    endtask

    // Monitor: completion pulses against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                for (int n = 0; n < NN; n++) begin
                    if (node_done[n]) begin
                        done_cnt[n]++;
                        checks++;
                        if (exp_q.size() == 0) begin
                            errors++;
                            $display("FAIL R11 unexpected completion: actual node %0d expected none", n);
                        end else begin
                            int e;
                            e = exp_q.pop_front();
                            if (e != n) begin
                                errors++;
                                $display("FAIL R3 completion order: actual node %0d expected node %0d", n, e);
                            end
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        chk("R1 reset port_req", port_req, 0);
        chk("R1 reset port_write", port_write, 0);
        chk("R1 reset node_done", node_done, 0);
        chk("R1 reset data_cancel", data_cancel, 0);

        // Taken branch: both roots run in parallel, AND join at node 4
        @(negedge clk); seq_start = 1; ctl_a_act = 5'b11011;
        @(negedge clk); seq_start = 0; ctl_a_act = 0;
        #2 chk("R2 no request one cycle after tokens", port_req, 0);
        @(negedge clk); #2;
        chk("R12 parallel requests on both ports", port_req, 2'b11);
        chk("R12 write flag only for the store port", port_write, 2'b10);
        @(negedge clk); exp_q.push_back(1); port_ack = 2'b10;
        #2 chk("R3 unacknowledged load request held", port_req[0], 1);
        @(negedge clk); port_ack = 0;
        #2 chk("R5 successor not issued yet", port_req, 2'b01);
        @(negedge clk); #2;
        chk("R5 OR join fired from store completion", port_req, 2'b11);
        chk("R12 load requests carry no write flag", port_write, 2'b00);
        @(negedge clk); exp_q.push_back(0); port_ack = 2'b01;
        @(negedge clk); port_ack = 0;
        #2 chk("R4 AND join waits for second predecessor", port_req, 2'b10);
        @(negedge clk); exp_q.push_back(3); port_ack = 2'b10;
        @(negedge clk); port_ack = 0;
        #2 chk("R3 request dropped after acknowledge", port_req, 0);
        @(negedge clk); #2;
        chk("R4 AND join fired after all predecessors", port_req, 2'b01);
        chk("R12 store on port 0 flags write", port_write, 2'b01);
        @(negedge clk); exp_q.push_back(4); port_ack = 2'b01;
        @(negedge clk); port_ack = 0;

        // Untaken branch: store killed, forwarder carries the order token
        do_reset();
        @(negedge clk); exp_q.push_back(2); seq_start = 1; ctl_a_act = 5'b11101; ctl_b_can = 5'b00010;
        @(negedge clk); seq_start = 0; ctl_a_act = 0; ctl_b_can = 0;
        #2;
        chk("R8 store backward cancel pulse", data_cancel, 5'b00010);
        chk("R6 forwarder makes no port request", port_req, 0);
        @(negedge clk); #2;
        chk("R8 backward cancel lasts one cycle", data_cancel, 0);
        chk("R6 OR successor not yet issued", port_req, 2'b01);
        @(negedge clk); #2;
        chk("R5 OR join fired from forwarder alone", port_req, 2'b11);
        chk("R8 killed store never writes", port_write, 2'b00);
        @(negedge clk); exp_q.push_back(0); exp_q.push_back(3); port_ack = 2'b11;
        @(negedge clk); port_ack = 0;
        #2 chk("R4 same-cycle predecessors: not issued yet", port_req, 0);
        @(negedge clk); #2;
        chk("R4 AND join with same-cycle completions", port_req, 2'b01);
        @(negedge clk); exp_q.push_back(4); port_ack = 2'b01;
        @(negedge clk); port_ack = 0;
        #2 chk("R11 cancelled store emitted no completion", done_cnt[1], 0);

        // Qualified edges on node 1
        do_reset();
        @(negedge clk); seq_start = 1; ctl_a_can = 5'b00010; ctl_b_act = 5'b00010;
        @(negedge clk); seq_start = 0; ctl_a_can = 0; ctl_b_act = 0;
        #2 chk("R7 cancel on activate-only edge dropped", data_cancel, 0);
        @(negedge clk);
        #2 chk("R7 activate on cancel-only edge dropped", port_req, 0);
        @(negedge clk); ctl_a_act = 5'b00010;
        #2 chk("R2 store without activate stays idle", port_req, 0);
        @(negedge clk); ctl_a_act = 0;
        #2 chk("R2 store one cycle after activate", port_req, 0);
        @(negedge clk); #2;
        chk("R7 store issues after admitted activate", port_req, 2'b10);
        chk("R7 store write flag", port_write, 2'b10);
        @(negedge clk); exp_q.push_back(1); port_ack = 2'b10;
        @(negedge clk); port_ack = 0;

        // Activate before order token
        do_reset();
        @(negedge clk); ctl_a_act = 5'b00001;
        @(negedge clk); ctl_a_act = 0;
        @(negedge clk);
        @(negedge clk);
        #2 chk("R2 activate alone gives no request", port_req, 0);
        @(negedge clk); seq_start = 1;
        @(negedge clk); seq_start = 0;
        #2 chk("R2 not yet after late order token", port_req, 0);
        @(negedge clk);
        #2 chk("R2 load issues when order token joins activate", port_req, 2'b01);
        @(negedge clk); exp_q.push_back(0); port_ack = 2'b01;
        @(negedge clk); port_ack = 0;

        // Load cancellation rules
        do_reset();
        @(negedge clk); seq_start = 1; ctl_a_can = 5'b00001;
        @(negedge clk); seq_start = 0; ctl_a_can = 0; res_cancel = 5'b00001;
        @(negedge clk); res_cancel = 0; ctl_a_act = 5'b00001;
        @(negedge clk); ctl_a_act = 0;
        @(negedge clk);
        #2 chk("R9 result-edge cancel removed order token", port_req, 0);
        @(negedge clk);
        #2 chk("R9 load stays idle without order token", port_req, 0);
        @(negedge clk); seq_start = 1;
        @(negedge clk); seq_start = 0;
        @(negedge clk);
        #2 chk("R9 control cancel never held by load", port_req, 2'b01);
        @(negedge clk); res_cancel = 5'b00001;
        @(negedge clk); res_cancel = 0;
        #2 chk("R10 cancelled load keeps request", port_req, 2'b01);
        @(negedge clk); port_ack = 2'b01;
        #2 chk("R10 drained acknowledge gives no completion", node_done, 0);
        @(negedge clk); port_ack = 0;
        #2 chk("R10 request released after drain", port_req, 0);
        chk("R10 drained load completion count", done_cnt[0], 0);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule